// File: doc/BRIEF.md
# Power Sequencer Script Engine

This block keeps short power-sequencing scripts in a small byte-wide instruction store and runs them when system events arrive. Each script is a chain of instructions. Every instruction holds a 16-bit resource message, a delay, and the index of the next instruction. A host fills the store through an indirect pair of registers: it writes a byte address, then the byte. The host also sets one entry pointer for each of four events: warm reset, active-to-sleep, wakeup of processor groups 1 and 2, and wakeup of group 3.

When an event is accepted, the engine fetches the four bytes of the entry instruction one per cycle. It then offers the message on a valid/ready stream. After the transfer it waits the programmed number of slow-tick pulses and follows the next pointer. The index value 0x3F is a terminator. As a next pointer it ends the script. As an entry pointer it disables that event.

The message stream obeys valid/ready rules. Once `msg_valid` is high, it stays high and `msg_data` stays constant until a cycle in which `msg_ready` is high. That cycle is the transfer. A sink may hold `msg_ready` low for as long as it needs, and the engine stalls in place without losing or repeating a message. The host port, the event inputs and the tick are plain strobes with no handshake.

Top module: `pseq_engine`

## Requirements
- R1: After reset `busy` and `msg_valid` are low. All four entry pointers read as 0x3F, so events have no effect until pointers are programmed.
- R2: A host write with `host_sel`=0 loads the byte address register. A write with `host_sel`=1 stores `host_wdata` at that address. Instruction n occupies bytes 4n to 4n+3, in this order: message high byte, message low byte, delay, next index. `msg_data` is {high, low}.
- R3: An event pulse is latched on the edge that samples it. On the next edge an idle engine accepts it and `busy` rises. After four byte-fetch cycles `msg_valid` rises with the first instruction.
- R4: While `msg_valid` is high and `msg_ready` is low, `msg_valid` stays high and `msg_data` holds. Each instruction transfers exactly once.
- R5: For a delay d greater than 0, after the transfer the engine counts d cycles with `tick` high, then spends one link cycle before the next fetch. A `tick` seen while the engine is not waiting is not counted.
- R6: For a delay of 0, the cycle after the transfer is the link cycle. `msg_valid` is therefore low for at least five cycles between two messages.
- R7: A next index of 0x3F ends the script, and `busy` falls after the link cycle. Index 0x3E is the last usable instruction slot.
- R8: An event whose entry pointer is 0x3F at acceptance is discarded. No message is issued and `busy` stays low.
- R9: Events that arrive while a script runs, or together, are held pending. When the engine is idle they are taken in fixed priority: `evt[0]` warm reset, then `evt[1]` active-to-sleep, then `evt[2]` wakeup of groups 1 and 2, then `evt[3]` wakeup of group 3. Writes with `host_sel` codes 2, 3, 4 and 5 set the entry pointers of `evt[0]`, `evt[1]`, `evt[2]` and `evt[3]`.
- R10: Several pulses of one event while it is pending merge into one run. A pulse of an event that arrives after that event was accepted makes it pending again.
- R11: An entry pointer is read at the acceptance edge. Store contents are read at fetch time, so host rewrites take effect at the next acceptance or fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 3 | Host register select (0 address, 1 data, 2..5 entry pointers) |
| host_wdata | input | 8 | Host write data |
| tick | input | 1 | Slow delay tick enable, one cycle wide |
| evt | input | 4 | Event pulses: warm reset, sleep, wake groups 1-2, wake group 3 |
| msg_valid | output | 1 | Resource message offered |
| msg_ready | input | 1 | Sink accepts the message |
| msg_data | output | 16 | Resource message |
| busy | output | 1 | A script is running |

## Verification
A wrong fetch slot or byte lane appears in `msg_data` at the first valid cycle of the affected instruction, four cycles after acceptance or after the link cycle. A broken delay counter or link step moves the next `msg_valid` rise or the fall of `busy` by at least one cycle, which a per-cycle model comparison catches in that cycle. A wrong pending priority or merge rule only shows when the queued scripts run. It is detected by comparing the order and count of transferred messages after a burst of overlapping events, or by `busy` staying high when it should have fallen.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_EV   = 4;
  localparam int SEL_W    = 3;
  localparam int INS_BYTES = 4;

  localparam logic [SEL_W-1:0] HSEL_ADDR = 3'd0;
  localparam logic [SEL_W-1:0] HSEL_DATA = 3'd1;
  localparam int               HSEL_PTR0 = 2;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_ISSUE,
    SQ_WAIT,
    SQ_NEXT
  } sq_state_t;
endpackage

// File: rtl/pseq_store.sv
module pseq_store
  import pseq_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              host_wr,
  input  logic [SEL_W-1:0]                  host_sel,
  input  logic [BYTE_W-1:0]                 host_wdata,
  input  logic [IDX_W+1:0]                  rd_addr,
  output logic [BYTE_W-1:0]                 rd_byte,
  output logic [NUM_EV-1:0][IDX_W-1:0]      entry
);
  localparam int AW    = IDX_W + 2;
  localparam int DEPTH = 1 << AW;
  localparam logic [IDX_W-1:0] TERM = {IDX_W{1'b1}};

  logic [AW-1:0]     waddr_q;
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
    end else if (host_wr && host_sel == HSEL_ADDR) begin
      waddr_q <= AW'(host_wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (host_wr && host_sel == HSEL_DATA) begin
      mem[waddr_q] <= host_wdata;
    end
  end

  assign rd_byte = mem[rd_addr];

  for (genvar g = 0; g < NUM_EV; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry[g] <= TERM;
      end else if (host_wr && host_sel == SEL_W'(HSEL_PTR0 + g)) begin
        entry[g] <= host_wdata[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pseq_pend.sv
module pseq_pend #(
  parameter int NUM = 4,
  parameter int PW  = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] evt,
  input  logic           take,
  output logic           any,
  output logic [PW-1:0]  pick
);
  logic [NUM-1:0] pend_q;
  logic [NUM-1:0] onehot;

  always_comb begin
    pick   = '0;
    onehot = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        pick   = PW'(i);
        onehot = NUM'(1) << i;
      end
    end
  end

  assign any = |pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q & ~(take ? onehot : '0)) | evt;
    end
  end
endmodule

// File: rtl/pseq_delay.sv
module pseq_delay #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             tick,
  output logic [DLY_W-1:0] cnt,
  output logic             done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = tick && (cnt == DLY_W'(1));
endmodule

// File: rtl/pseq_engine.sv
module pseq_engine
  import pseq_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [2:0]  host_sel,
  input  logic [7:0]  host_wdata,
  input  logic        tick,
  input  logic [3:0]  evt,
  output logic        msg_valid,
  input  logic        msg_ready,
  output logic [15:0] msg_data,
  output logic        busy
);
  localparam int PW = $clog2(NUM_EV);
  localparam int BW = $clog2(INS_BYTES);
  localparam logic [IDX_W-1:0] TERM = {IDX_W{1'b1}};

  sq_state_t                   state_q;
  logic [IDX_W-1:0]            ptr_q;
  logic [BW-1:0]               bsel_q;
  logic [BYTE_W-1:0]           ins_q [INS_BYTES];
  logic [BYTE_W-1:0]           rd_byte;
  logic [NUM_EV-1:0][IDX_W-1:0] entry;
  logic                        pend_any;
  logic [PW-1:0]               pick;
  logic                        take;
  logic [IDX_W-1:0]            sel_entry;
  logic [IDX_W-1:0]            nxt_idx;
  logic                        dly_load;
  logic                        dly_done;
  logic [BYTE_W-1:0]           dly_cnt;

  pseq_store #(.IDX_W(IDX_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .rd_addr    ({ptr_q, bsel_q}),
    .rd_byte    (rd_byte),
    .entry      (entry)
  );

  pseq_pend #(.NUM(NUM_EV), .PW(PW)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt),
    .take  (take),
    .any   (pend_any),
    .pick  (pick)
  );

  pseq_delay #(.DLY_W(BYTE_W)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dly_load),
    .load_val (ins_q[2]),
    .tick     (tick),
    .cnt      (dly_cnt),
    .done     (dly_done)
  );

  assign take      = (state_q == SQ_IDLE) && pend_any;
  assign sel_entry = entry[pick];
  assign nxt_idx   = ins_q[3][IDX_W-1:0];
  assign dly_load  = (state_q == SQ_ISSUE) && msg_ready && (ins_q[2] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      ptr_q   <= '0;
      bsel_q  <= '0;
      for (int i = 0; i < INS_BYTES; i++) ins_q[i] <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (take && sel_entry != TERM) begin
            ptr_q   <= sel_entry;
            bsel_q  <= '0;
            state_q <= SQ_FETCH;
          end
        end
        SQ_FETCH: begin
          ins_q[bsel_q] <= rd_byte;
          bsel_q        <= bsel_q + 1'b1;
          if (bsel_q == BW'(INS_BYTES - 1)) state_q <= SQ_ISSUE;
        end
        SQ_ISSUE: begin
          if (msg_ready) state_q <= (ins_q[2] == '0) ? SQ_NEXT : SQ_WAIT;
        end
        SQ_WAIT: begin
          if (dly_done) state_q <= SQ_NEXT;
        end
        SQ_NEXT: begin
          if (nxt_idx == TERM) begin
            state_q <= SQ_IDLE;
          end else begin
            ptr_q   <= nxt_idx;
            bsel_q  <= '0;
            state_q <= SQ_FETCH;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != SQ_IDLE);
  assign msg_valid = (state_q == SQ_ISSUE);
  assign msg_data  = {ins_q[0], ins_q[1]};
endmodule

// File: rtl/pseq_engine_chk.sv
module pseq_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic [15:0] msg_data,
  input logic        tick,
  input logic        in_wait,
  input logic [7:0]  dly_cnt
);
  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_data))); // R4

  AST_OFFER_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> busy); // R3

  AST_FETCH_BEFORE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !msg_valid); // R3

  AST_GAP_AFTER_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> !msg_valid); // R6

  AST_WAIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !tick) |=> $stable(dly_cnt)); // R5

  AST_WAIT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> (dly_cnt != 8'd0)); // R5
endmodule

bind pseq_engine pseq_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_data  (msg_data),
  .tick      (tick),
  .in_wait   (state_q == pseq_pkg::SQ_WAIT),
  .dly_cnt   (dly_cnt)
);

// File: tb/tb_pseq_engine.sv
module tb_pseq_engine;
  localparam int CLK_PERIOD = 10;
  localparam int TERM = 63;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [2:0]  host_sel = '0;
  logic [7:0]  host_wdata = '0;
  logic        tick = 1'b0;
  logic [3:0]  evt = '0;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic [15:0] msg_data;
  logic        busy;

  pseq_engine dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .tick(tick), .evt(evt), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_data(msg_data), .busy(busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit tick_en = 1'b1;
  bit bp_mode = 1'b0;
  int tick_div = 0;
  int log_q[$];

  // behavioural reference model
  int m_state;            // 0 idle 1 fetch 2 issue 3 wait 4 link
  int m_pend[4];
  int m_entry[4];
  int m_addr;
  int m_mem[256];
  int m_ptr, m_k, m_cnt;
  int m_b[4];
  int clr;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_addr = 0; m_ptr = 0; m_k = 0; m_cnt = 0;
      for (int i = 0; i < 4; i++) begin
        m_pend[i] = 0; m_entry[i] = TERM; m_b[i] = 0;
      end
    end else begin
      clr = -1;
      case (m_state)
        0: begin
          for (int i = 3; i >= 0; i--) if (m_pend[i] != 0) clr = i;
          if (clr >= 0 && m_entry[clr] != TERM) begin
            m_ptr = m_entry[clr]; m_k = 0; m_state = 1;
          end
        end
        1: begin
          m_b[m_k] = m_mem[m_ptr * 4 + m_k];
          if (m_k == 3) m_state = 2;
          m_k = m_k + 1;
        end
        2: if (msg_ready) begin
          if (m_b[2] == 0) m_state = 4;
          else begin m_cnt = m_b[2]; m_state = 3; end
        end
        3: if (tick) begin
          if (m_cnt == 1) m_state = 4;
          m_cnt = m_cnt - 1;
        end
        default: begin
          if ((m_b[3] % 64) == TERM) m_state = 0;
          else begin m_ptr = m_b[3] % 64; m_k = 0; m_state = 1; end
        end
      endcase
      for (int i = 0; i < 4; i++) begin
        if (i == clr) m_pend[i] = 0;
        if (evt[i]) m_pend[i] = 1;
      end
      if (host_wr) begin
        if (host_sel == 3'd0) m_addr = host_wdata;
        else if (host_sel == 3'd1) m_mem[m_addr] = host_wdata;
        else if (host_sel >= 3'd2 && host_sel <= 3'd5) m_entry[host_sel - 2] = host_wdata % 64;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == (m_state != 0), "R3 busy", busy, m_state != 0);
      chk(msg_valid == (m_state == 2), "R4 valid", msg_valid, m_state == 2);
      if (m_state == 2)
        chk(msg_data == 16'((m_b[0] << 8) | m_b[1]), "R2 data", msg_data, (m_b[0] << 8) | m_b[1]);
      if (msg_valid && msg_ready) log_q.push_back(int'(msg_data));
    end
  end

  always @(posedge clk) begin
    #2;
    tick_div = (tick_div + 1) % 3;
    tick <= tick_en && (tick_div == 0);
    msg_ready <= bp_mode ? 1'($urandom % 2) : 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL R3 watchdog act=%0d exp=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic hw(input logic [2:0] sel, input logic [7:0] d);
    @(posedge clk); #2;
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(posedge clk); #2;
    host_wr = 1'b0;
  endtask

  task automatic load_ins(input int idx, input int msg, input int dly, input int nxt);
    hw(3'd0, 8'(idx * 4));     hw(3'd1, 8'(msg >> 8));
    hw(3'd0, 8'(idx * 4 + 1)); hw(3'd1, 8'(msg));
    hw(3'd0, 8'(idx * 4 + 2)); hw(3'd1, 8'(dly));
    hw(3'd0, 8'(idx * 4 + 3)); hw(3'd1, 8'(nxt));
  endtask

  task automatic fire(input logic [3:0] m);
    @(posedge clk); #2; evt = m;
    @(posedge clk); #2; evt = '0;
  endtask

  task automatic wait_quiet();
    for (int n = 0; n < 4000; n++) begin
      @(posedge clk);
      if (m_state == 0 && m_pend[0] == 0 && m_pend[1] == 0 && m_pend[2] == 0 && m_pend[3] == 0) break;
    end
    repeat (3) @(posedge clk);
  endtask

  task automatic expect_log(input int exp[$], input string tag);
    chk(log_q.size() == exp.size(), tag, log_q.size(), exp.size());
    for (int i = 0; i < exp.size() && i < log_q.size(); i++)
      chk(log_q[i] == exp[i], tag, log_q[i], exp[i]);
    log_q.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(msg_valid == 1'b0, "R1 valid after reset", msg_valid, 0);
    // unprogrammed pointers: events do nothing
    fire(4'b1111);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R1 events ignored", busy, 0);
    expect_log('{}, "R1 no messages");

    // programs
    load_ins(0, 16'h1234, 2, 1);
    load_ins(1, 16'hABCD, 0, TERM);
    load_ins(5, 16'h5A5A, 1, TERM);
    load_ins(10, 16'h0F0F, 0, 11);
    load_ins(11, 16'h7777, 3, TERM);
    load_ins(62, 16'hBEEF, 0, TERM);     // last usable slot R7
    hw(3'd2, 8'd0); hw(3'd3, 8'd5); hw(3'd4, 8'd10); hw(3'd5, 8'd62);

    // single run with zero and nonzero delays
    fire(4'b0100);
    wait_quiet();
    expect_log('{16'h0F0F, 16'h7777}, "R3 R6 R7 single script");

    // overlap: priority and merge
    fire(4'b1000);
    repeat (2) @(posedge clk);
    fire(4'b0010); fire(4'b0011); fire(4'b0010);
    wait_quiet();
    expect_log('{16'hBEEF, 16'h1234, 16'hABCD, 16'h5A5A}, "R9 R10 priority order");

    // re-arm during own run
    fire(4'b0001);
    repeat (8) @(posedge clk);
    fire(4'b0001);
    wait_quiet();
    expect_log('{16'h1234, 16'hABCD, 16'h1234, 16'hABCD}, "R10 re-arm");

    // back-pressure
    bp_mode = 1'b1;
    fire(4'b0101);
    wait_quiet();
    expect_log('{16'h1234, 16'hABCD, 16'h0F0F, 16'h7777}, "R4 back-pressure");
    bp_mode = 1'b0;

    // delay stalls without ticks
    tick_en = 1'b0;
    fire(4'b0010);
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b1, "R5 stalled busy", busy, 1);
    chk(msg_valid == 1'b0, "R5 stalled valid", msg_valid, 0);
    tick_en = 1'b1;
    wait_quiet();
    expect_log('{16'h5A5A}, "R5 resumes");

    // disabled entry
    hw(3'd3, 8'd63);
    fire(4'b0010);
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R8 disabled event", busy, 0);
    expect_log('{}, "R8 no message");

    // rewrites take effect
    load_ins(5, 16'h1111, 0, TERM);
    hw(3'd3, 8'd5); hw(3'd5, 8'd5);
    fire(4'b1000);
    wait_quiet();
    fire(4'b0010);
    wait_quiet();
    expect_log('{16'h1111, 16'h1111}, "R11 rewrite");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule